// File: doc/BRIEF.md
# Locked 64-bit Compare-and-Swap Bus Sequencer

This block performs the memory half of an atomic 64-bit compare-and-swap on a system whose data bus is only 32 bits wide. A client hands it a byte address, a 64-bit expected value and a 64-bit replacement. The block reads the quadword at that address in bus-sized pieces and compares it with the expected value. It then writes the quadword back in pieces: the replacement when the values match, the unchanged original when they do not. The bus lock is held from the first read until the last write has been acknowledged, so no other master can see a half-updated quadword.

Transfers are never widened or merged. Two read cycles always come before two write cycles. An address that is not a multiple of four makes every read and every write straddle a dword boundary, so each one is cut into a lower-address piece and a higher-address piece, for eight bus cycles in total. A separate split-cycle output marks every cycle of the four-cycle aligned sequence. When the last write is acknowledged, the block returns the quadword it read and a success flag.

Top module: `cx8_atomic_seq`

## Requirements
- R1: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the operation finishes, and any request presented while it is low is ignored.
- R2: When `req_addr[1:0]` is 0, exactly four bus cycles are issued: a read of dword A/4 and then a read of A/4+1, both with `bus_be` = 1111, followed by writes to the same two dwords in the same order. `bus_split` is high on all four cycles.
- R3: When `req_addr[1:0]` = o is not 0, each 32-bit half is sent as two pieces, lower address first, giving eight cycles. With hi = 1111 shifted left by o (4 bits kept) and lo = ~hi, the pieces are: dword A/4 with hi, A/4+1 with lo, A/4+1 with hi, A/4+2 with lo. `bus_split` stays low.
- R4: Every read cycle (`bus_wr` = 0) comes before any write cycle (`bus_wr` = 1).
- R5: `bus_lock` is high on every bus cycle and between cycles of an operation. It falls in the cycle after `bus_rdy` has been sampled for the final write.
- R6: `bus_cyc`, `bus_addr`, `bus_be`, `bus_wr` and `bus_wdata` hold steady until `bus_rdy` is sampled high, so any number of wait states is accepted. Each ready ends exactly one cycle.
- R7: Byte j of the 64-bit operand (bits 8j+7:8j) belongs to byte address A+j. On the bus that is lane (A+j) mod 4 of dword (A+j)/4, little-endian. Writes change only the eight addressed bytes.
- R8: When the assembled read value equals `req_cmp`, `req_swap` is written and `success` is 1. Any difference, including one only in bit 63, writes back the value that was read and gives `success` = 0.
- R9: `done` pulses for one cycle, one clock after the final write's ready. `old_val` then holds the quadword that was read, and `old_val` and `success` keep their values until the next `done`.
- R10: While reset is active and right after it: `req_ready` = 1, and `bus_cyc`, `bus_lock`, `bus_split` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the quadword |
| req_cmp | input | 2*BUS_W | Expected value |
| req_swap | input | 2*BUS_W | Replacement value |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_addr | output | ADDR_W | Dword-aligned byte address of the cycle |
| bus_be | output | BUS_W/8 | Byte lane enables |
| bus_wr | output | 1 | 1 for write, 0 for read |
| bus_wdata | output | BUS_W | Write data |
| bus_rdata | input | BUS_W | Read data |
| bus_rdy | input | 1 | Cycle completion from memory |
| bus_lock | output | 1 | Bus lock held for the whole operation |
| bus_split | output | 1 | Marks the cycles of an aligned sequence |
| done | output | 1 | One-cycle completion pulse |
| old_val | output | 2*BUS_W | Quadword read from memory |
| success | output | 1 | The compare matched and the replacement was written |

## Verification
The assertions check on every cycle the properties that can be judged locally. These are: lock covering each bus cycle, cycle signals held steady through wait states, a nonzero lane mask, full lanes whenever the split marker is up, the read phase always giving way to the write phase through the compare step, and `done` coming only right after an acknowledged write. Some behaviour can only be shown by the bench scenarios, which compare the whole cycle trace and the final memory image with values worked out independently. That covers the exact order of addresses and lane masks for each byte offset, the placement of bytes on the lanes, the choice between writing the replacement and writing back the original, the returned old value and flag, and the fact that a request made while busy is ignored.

// File: rtl/cx8_pkg.sv
`timescale 1ns/1ps
package cx8_pkg;

   // Operation phases of the sequencer.
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_EVAL  = 3'd2,
      ST_WRITE = 3'd3
   } cx8_state_e;

   // An operation touches at most three consecutive bus words.
   localparam int WIN_WORDS = 3;
   localparam int PIECE_W   = 2;
   localparam int SEL_W     = 2;

endpackage

// File: rtl/cx8_piece_map.sv
`timescale 1ns/1ps
// Maps a piece index to the bus word, lane mask and window slot it covers.
module cx8_piece_map
   import cx8_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BUS_W  = 32
) (
   input  logic [ADDR_W-$clog2(BUS_W/8)-1:0] base_word,
   input  logic [$clog2(BUS_W/8)-1:0]        ofs,
   input  logic [PIECE_W-1:0]                piece,
   output logic [ADDR_W-$clog2(BUS_W/8)-1:0] word_addr,
   output logic [BUS_W/8-1:0]                be,
   output logic [SEL_W-1:0]                  sel
);
   localparam int BYTES = BUS_W / 8;
   localparam int OFS_W = $clog2(BYTES);
   localparam int WA_W  = ADDR_W - OFS_W;

   logic [BYTES-1:0]   hi_mask;
   logic [BYTES-1:0]   lo_mask;
   logic [PIECE_W:0]   piece_inc;
   logic               aligned;

   assign aligned   = (ofs == '0);
   assign hi_mask   = {BYTES{1'b1}} << ofs;
   assign lo_mask   = ~hi_mask;
   assign piece_inc = {1'b0, piece} + {{PIECE_W{1'b0}}, 1'b1};

   always_comb begin
      if (aligned) begin
         // Whole words: piece 0 -> slot 0, piece 1 -> slot 1.
         sel = piece;
         be  = {BYTES{1'b1}};
      end else begin
         // Straddling: slots 0,1,1,2 with upper-lane / lower-lane masks.
         sel = piece_inc[PIECE_W:1];
         be  = piece[0] ? lo_mask : hi_mask;
      end
   end

   assign word_addr = base_word + {{(WA_W-SEL_W){1'b0}}, sel};

endmodule

// File: rtl/cx8_lane_window.sv
`timescale 1ns/1ps
// Three-word byte window: gathers read pieces and slices write data.
module cx8_lane_window
   import cx8_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cap,
   input  logic [SEL_W-1:0]            sel,
   input  logic [BUS_W/8-1:0]          be,
   input  logic [BUS_W-1:0]            rdata,
   input  logic [$clog2(BUS_W/8)-1:0]  ofs,
   input  logic [2*BUS_W-1:0]          wval,
   output logic [2*BUS_W-1:0]          rd_val,
   output logic [BUS_W-1:0]            wdata
);
   localparam int BYTES = BUS_W / 8;
   localparam int OP_W  = 2 * BUS_W;
   localparam int WIN_W = WIN_WORDS * BUS_W;

   logic [WIN_W-1:0] win_flat;
   logic [WIN_W-1:0] wr_shift;

   for (genvar w = 0; w < WIN_WORDS; w++) begin : g_word
      logic [BUS_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (cap && (sel == SEL_W'(w))) begin
            for (int b = 0; b < BYTES; b++) begin
               if (be[b]) word_q[b*8 +: 8] <= rdata[b*8 +: 8];
            end
         end
      end
      assign win_flat[w*BUS_W +: BUS_W] = word_q;
   end

   // Operand byte j sits at window byte ofs+j.
   assign rd_val   = win_flat[{ofs, 3'b000} +: OP_W];
   assign wr_shift = {{BUS_W{1'b0}}, wval} << {ofs, 3'b000};

   always_comb begin
      case (sel)
         2'd0:    wdata = wr_shift[BUS_W-1:0];
         2'd1:    wdata = wr_shift[2*BUS_W-1:BUS_W];
         default: wdata = wr_shift[3*BUS_W-1:2*BUS_W];
      endcase
   end

endmodule

// File: rtl/cx8_ctrl.sv
`timescale 1ns/1ps
// Phase and piece sequencing: all reads, one compare step, all writes.
module cx8_ctrl
   import cx8_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                aligned,
   input  logic                rdy,
   output cx8_state_e          state,
   output logic [PIECE_W-1:0]  piece,
   output logic                rd_take,
   output logic                eval_now,
   output logic                wr_last
);
   logic [PIECE_W-1:0] last_piece;
   logic               on_last;

   assign last_piece = aligned ? PIECE_W'(1) : PIECE_W'(3);
   assign on_last    = (piece == last_piece);
   assign rd_take    = (state == ST_READ) && rdy;
   assign eval_now   = (state == ST_EVAL);
   assign wr_last    = (state == ST_WRITE) && rdy && on_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         piece <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_READ;
                  piece <= '0;
               end
            end
            ST_READ: begin
               if (rdy) begin
                  if (on_last) begin
                     state <= ST_EVAL;
                     piece <= '0;
                  end else begin
                     piece <= piece + PIECE_W'(1);
                  end
               end
            end
            ST_EVAL: begin
               state <= ST_WRITE;
            end
            ST_WRITE: begin
               if (rdy) begin
                  if (on_last) begin
                     state <= ST_IDLE;
                     piece <= '0;
                  end else begin
                     piece <= piece + PIECE_W'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4: the write phase is entered only from the compare step.
   a_r4_write_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WRITE && $past(state) != ST_WRITE) |-> $past(state) == ST_EVAL)
      else $error("write phase entered without completing reads");

   // R3: piece index never passes the last piece of the current shape.
   a_r3_piece_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READ || state == ST_WRITE) |-> piece <= last_piece)
      else $error("piece index out of range");

endmodule

// File: rtl/cx8_atomic_seq.sv
`timescale 1ns/1ps
module cx8_atomic_seq
   import cx8_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BUS_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [2*BUS_W-1:0]   req_cmp,
   input  logic [2*BUS_W-1:0]   req_swap,
   output logic                 bus_cyc,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [BUS_W/8-1:0]   bus_be,
   output logic                 bus_wr,
   output logic [BUS_W-1:0]     bus_wdata,
   input  logic [BUS_W-1:0]     bus_rdata,
   input  logic                 bus_rdy,
   output logic                 bus_lock,
   output logic                 bus_split,
   output logic                 done,
   output logic [2*BUS_W-1:0]   old_val,
   output logic                 success
);
   localparam int BYTES = BUS_W / 8;
   localparam int OFS_W = $clog2(BYTES);
   localparam int OP_W  = 2 * BUS_W;
   localparam int WA_W  = ADDR_W - OFS_W;

   if (BUS_W < 16 || (BUS_W & (BUS_W - 1)) != 0) begin : g_bad_bus
      $error("cx8_atomic_seq: BUS_W must be a power of two, at least 16");
   end
   if (ADDR_W <= OFS_W + 2) begin : g_bad_addr
      $error("cx8_atomic_seq: ADDR_W too small for a three-word window");
   end

   cx8_state_e          state;
   logic [PIECE_W-1:0]  piece;
   logic                rd_take;
   logic                eval_now;
   logic                wr_last;
   logic                start;

   logic [ADDR_W-1:0]   addr_q;
   logic [OP_W-1:0]     cmp_q;
   logic [OP_W-1:0]     swap_q;
   logic [OP_W-1:0]     wval_q;
   logic                match_q;
   logic                done_q;
   logic [OP_W-1:0]     old_q;
   logic                succ_q;

   logic [OFS_W-1:0]    ofs;
   logic [WA_W-1:0]     base_word;
   logic                aligned;
   logic [WA_W-1:0]     word_addr;
   logic [SEL_W-1:0]    sel;
   logic [BYTES-1:0]    be;
   logic [OP_W-1:0]     read_val;

   assign ofs       = addr_q[OFS_W-1:0];
   assign base_word = addr_q[ADDR_W-1:OFS_W];
   assign aligned   = (ofs == '0);
   assign req_ready = (state == ST_IDLE);
   assign start     = req_valid && req_ready;

   cx8_ctrl i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .aligned  (aligned),
      .rdy      (bus_rdy),
      .state    (state),
      .piece    (piece),
      .rd_take  (rd_take),
      .eval_now (eval_now),
      .wr_last  (wr_last)
   );

   cx8_piece_map #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) i_map (
      .base_word (base_word),
      .ofs       (ofs),
      .piece     (piece),
      .word_addr (word_addr),
      .be        (be),
      .sel       (sel)
   );

   cx8_lane_window #(.BUS_W(BUS_W)) i_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap    (rd_take),
      .sel    (sel),
      .be     (be),
      .rdata  (bus_rdata),
      .ofs    (ofs),
      .wval   (wval_q),
      .rd_val (read_val),
      .wdata  (bus_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cmp_q   <= '0;
         swap_q  <= '0;
         wval_q  <= '0;
         match_q <= 1'b0;
         done_q  <= 1'b0;
         old_q   <= '0;
         succ_q  <= 1'b0;
      end else begin
         if (start) begin
            addr_q <= req_addr;
            cmp_q  <= req_cmp;
            swap_q <= req_swap;
         end
         if (eval_now) begin
            match_q <= (read_val == cmp_q);
            wval_q  <= (read_val == cmp_q) ? swap_q : read_val;
         end
         done_q <= wr_last;
         if (wr_last) begin
            old_q  <= read_val;
            succ_q <= match_q;
         end
      end
   end

   assign bus_cyc   = (state == ST_READ) || (state == ST_WRITE);
   assign bus_wr    = (state == ST_WRITE);
   assign bus_lock  = (state == ST_READ) || (state == ST_EVAL) || (state == ST_WRITE);
   assign bus_split = bus_lock && aligned;
   assign bus_addr  = {word_addr, {OFS_W{1'b0}}};
   assign bus_be    = be;
   assign done      = done_q;
   assign old_val   = old_q;
   assign success   = succ_q;

   // R1: taking a request makes the block busy on the next cycle.
   a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready)
      else $error("request taken but sequencer still idle");

   // R5: no bus cycle runs without the lock.
   a_r5_lock_on_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc |-> bus_lock)
      else $error("bus cycle without lock");

   // R5: lock is already released when completion is reported.
   a_r5_lock_free_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_lock)
      else $error("lock still held at completion");

   // R6: cycle attributes stay put through wait states.
   a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_rdy) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be)
                                 && $stable(bus_wr) && $stable(bus_wdata)))
      else $error("bus cycle changed before ready");

   // R3: every cycle enables at least one lane.
   a_r3_lanes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc |-> (bus_be != '0))
      else $error("bus cycle with no lanes");

   // R2: split-marked cycles are full-width.
   a_r2_split_full_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && bus_split) |-> (&bus_be))
      else $error("split-marked cycle is not full width");

   // R9: completion follows an acknowledged write.
   a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bus_cyc && bus_rdy && bus_wr))
      else $error("done without a final write");

endmodule

// File: tb/test_cx8_atomic_seq.sv
`timescale 1ns/1ps
module test_cx8_atomic_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_addr;
   logic [63:0] req_cmp;
   logic [63:0] req_swap;
   logic        bus_cyc;
   logic [31:0] bus_addr;
   logic [3:0]  bus_be;
   logic        bus_wr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        bus_rdy;
   logic        bus_lock;
   logic        bus_split;
   logic        done;
   logic [63:0] old_val;
   logic        success;

   always #2 clk = ~clk;

   cx8_atomic_seq #(.ADDR_W(32), .BUS_W(32)) i_cx8_atomic_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_cmp(req_cmp), .req_swap(req_swap),
      .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
      .bus_lock(bus_lock), .bus_split(bus_split), .done(done),
      .old_val(old_val), .success(success)
   );

   int checks = 0;
   int errors = 0;

   logic [31:0] mem     [64];
   logic [31:0] mem_pre [64];
   logic [31:0] exp_img [64];
   int  wait_states = 0;
   int  wcnt = 0;
   int  tn = 0;
   int  gap = 0;
   bit  busy = 1'b0;
   logic [31:0] tr_addr  [16];
   logic [3:0]  tr_be    [16];
   logic        tr_wr    [16];
   logic        tr_lock  [16];
   logic        tr_split [16];

   // {wait[1:0], mode[1:0], addr[7:0]}; mode 1 = match, 0 = low bit differs, 2 = bit 63 differs
   localparam logic [11:0] VEC [8] = '{
      {2'd0, 2'd1, 8'h10}, {2'd1, 2'd0, 8'h24}, {2'd0, 2'd1, 8'h31}, {2'd2, 2'd0, 8'h42},
      {2'd1, 2'd1, 8'h53}, {2'd0, 2'd0, 8'h61}, {2'd0, 2'd1, 8'h7A}, {2'd3, 2'd1, 8'h8C}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Memory responder and cycle recorder, acting away from the rising edge.
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_rdy = 1'b0;
         wcnt = 0;
      end else begin
         if (busy && !bus_lock && !done) gap++;
         if (bus_cyc) begin
            if (wcnt >= wait_states) begin
               bus_rdy = 1'b1;
               wcnt = 0;
               bus_rdata = mem[bus_addr[7:2]];
               if (bus_wr) begin
                  for (int b = 0; b < 4; b++)
                     if (bus_be[b]) mem[bus_addr[7:2]][b*8 +: 8] = bus_wdata[b*8 +: 8];
               end
               if (tn < 16) begin
                  tr_addr[tn]  = bus_addr;
                  tr_be[tn]    = bus_be;
                  tr_wr[tn]    = bus_wr;
                  tr_lock[tn]  = bus_lock;
                  tr_split[tn] = bus_split;
               end
               tn++;
            end else begin
               bus_rdy = 1'b0;
               wcnt++;
            end
         end else begin
            bus_rdy = 1'b0;
            wcnt = 0;
         end
      end
   end

   task automatic init_mem(input int seed);
      for (int i = 0; i < 64; i++)
         mem[i] = (32'h9E3779B9 * 32'(i + 1)) ^ {8'(seed), 24'h0} ^ (32'(i) * 32'h00010203);
   endtask

   function automatic logic [7:0] pre_byte(input int ad);
      return mem_pre[ad / 4][(ad % 4) * 8 +: 8];
   endfunction

   task automatic run_op(input logic [31:0] a, input logic [63:0] c, input logic [63:0] s,
                         input int w, input bit poke, output bit got,
                         output logic [63:0] ov, output logic sv, output logic lk);
      wait_states = w;
      tn = 0;
      gap = 0;
      @(negedge clk);
      req_addr = a; req_cmp = c; req_swap = s; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      busy = 1'b1;
      chk(req_ready == 1'b0, "R1 busy after take", 64'(req_ready), 64'd0);
      if (poke) begin
         req_valid = 1'b1; req_addr = 32'h0; req_cmp = '0; req_swap = '1;
      end
      for (int k = 0; k < 400 && !done; k++) @(negedge clk);
      req_valid = 1'b0;
      busy = 1'b0;
      got = done;
      ov = old_val;
      sv = success;
      lk = bus_lock;
   endtask

   task automatic do_case(input int a, input int mode, input int w, input bit poke);
      logic [63:0] orig, cmp, swp, ov;
      logic sv, lk, exp_s;
      bit got, aligned;
      int n, half, bad, order_bad, split_bad, diffs, o;
      logic [3:0] hi, lo, ebe;
      int esel;
      mem_pre = mem;
      for (int j = 0; j < 8; j++) orig[j*8 +: 8] = pre_byte(a + j);
      cmp = (mode == 1) ? orig : (mode == 2) ? (orig ^ 64'h8000_0000_0000_0000) : (orig ^ 64'h1);
      swp = {32'hC0DE0000 | 32'(a), ~32'(a)};
      exp_s = (mode == 1);
      run_op(32'(a), cmp, swp, w, poke, got, ov, sv, lk);
      chk(got, "R9 done pulse", 64'(got), 64'd1);
      chk(ov == orig, "R9 old value", ov, orig);
      chk(sv == exp_s, "R8 success flag", 64'(sv), 64'(exp_s));
      chk(lk == 1'b0, "R5 lock released at done", 64'(lk), 64'd0);
      chk(gap == 0, "R5 lock held through operation", 64'(gap), 64'd0);
      o = a % 4;
      aligned = (o == 0);
      n = aligned ? 4 : 8;
      half = n / 2;
      chk(tn == n, "R6 one cycle per ready (R1 no extra op)", 64'(tn), 64'(n));
      hi = 4'((4'hF << o) & 4'hF);
      lo = ~hi;
      bad = 0; order_bad = 0; split_bad = 0;
      for (int i = 0; i < n && i < tn; i++) begin
         int p;
         p = i % half;
         if (aligned) begin esel = p; ebe = 4'hF; end
         else begin esel = (p + 1) / 2; ebe = (p % 2 == 1) ? lo : hi; end
         if (tr_addr[i] != 32'(((a / 4) + esel) * 4) || tr_be[i] != ebe || tr_lock[i] != 1'b1) bad++;
         if (tr_wr[i] != (i >= half)) order_bad++;
         if (tr_split[i] != aligned) split_bad++;
      end
      chk(bad == 0, aligned ? "R2 aligned addresses and lanes" : "R3 split pieces",
          64'(bad), 64'd0);
      chk(order_bad == 0, "R4 reads before writes", 64'(order_bad), 64'd0);
      chk(split_bad == 0, aligned ? "R2 split indicator" : "R3 split indicator low",
          64'(split_bad), 64'd0);
      exp_img = mem_pre;
      if (exp_s) begin
         for (int j = 0; j < 8; j++)
            exp_img[(a + j) / 4][((a + j) % 4) * 8 +: 8] = swp[j*8 +: 8];
      end
      diffs = 0;
      for (int i = 0; i < 64; i++) if (mem[i] != exp_img[i]) diffs++;
      chk(diffs == 0, "R7 byte lanes in memory image", 64'(diffs), 64'd0);
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] held;
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_addr = '0; req_cmp = '0; req_swap = '0;
      bus_rdy = 1'b0;
      bus_rdata = '0;
      init_mem(0);
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(req_ready == 1'b1, "R10 ready in reset", 64'(req_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
      chk(bus_cyc == 1'b0 && bus_split == 1'b0, "R10 bus idle", {62'd0, bus_cyc, bus_split}, 64'd0);
      chk(bus_lock == 1'b0, "R10 lock low", 64'(bus_lock), 64'd0);
      chk(done == 1'b0, "R10 done low", 64'(done), 64'd0);

      // Table of scenarios covering every byte offset, both outcomes and wait states.
      for (int v = 0; v < 8; v++) begin
         init_mem(v + 1);
         do_case(int'(VEC[v][7:0]), int'(VEC[v][9:8]), int'(VEC[v][11:10]), 1'b0);
      end

      // R1: a request presented while busy is ignored.
      init_mem(20);
      do_case(32'h20, 1, 1, 1'b1);
      // R9: results held after the pulse.
      held = old_val;
      repeat (5) @(negedge clk);
      chk(old_val == held, "R9 old value held", old_val, held);
      chk(done == 1'b0, "R9 done is a single pulse", 64'(done), 64'd0);

      // R8: difference only in bit 63, misaligned.
      init_mem(30);
      do_case(32'h45, 2, 0, 1'b0);
      // R3: offset 3 at the top of the memory range.
      init_mem(31);
      do_case(32'hF3, 1, 2, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule